// File: doc/BRIEF.md
# Per-Load Stride Prefetcher

This block watches the stream of load instructions leaving a core and learns, for each load, whether it walks memory with a fixed step. Every observed load presents its program counter and its data address. A direct-mapped table, selected by low program-counter bits and guarded by a tag made of the remaining high bits, keeps one record per load. Each record holds the last address that load touched, a candidate step (stride) and a two-bit confidence state.

A small per-record state machine judges each new address. The prediction is correct when the new address equals the stored address plus the stored stride. After enough correct predictions the record reaches its confident state. From then on each correct observation makes the block emit a single-cycle prefetch request for the address one stride further ahead. Loads that never settle on a step are parked in a no-prediction state until they show a repeating step again. Filling the cache, memory traffic and buffering of prefetched lines belong to other blocks.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset `pf_valid` is low and every table record is empty, so the first observation of any program counter produces no prefetch.
- R2: An observation whose record is empty or holds a different tag (tag = `obs_pc[PC_W-1:IDX_LSB+IDX_W]`, index = `obs_pc[IDX_LSB +: IDX_W]`) overwrites the record with the current address, a stride of zero and the init state, and produces no prefetch.
- R3: On a hit the prediction counts as correct exactly when `obs_addr` equals stored address plus stored stride (modulo 2^ADDR_W), and the stored address becomes `obs_addr` on every hit.
- R4: A record in init moves to steady on a correct prediction; on a wrong one it moves to transient and its stride becomes `obs_addr` minus the stored address.
- R5: A record in transient moves to steady on a correct prediction; on a wrong one it moves to no-prediction and its stride is replaced by the new difference.
- R6: A record in steady stays in steady on a correct prediction; on a wrong one it returns to init and keeps its stride.
- R7: A record in no-prediction moves to transient on a correct prediction; on a wrong one it stays and its stride is replaced by the new difference.
- R8: A prefetch is issued exactly when a hit is correct and the record ends in steady; `pf_valid` rises in the cycle after the observation with `pf_addr` = `obs_addr` + stride.
- R9: No prefetch is issued while the stride in use is zero, even when the record is in steady.
- R10: `pf_valid` is a one-cycle pulse: it is low in any cycle that follows a cycle without an observation.
- R11: Two program counters with the same index bits but different tags evict each other's record, each eviction being an allocation as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| obs_valid | input | 1 | A load is observed this cycle |
| obs_pc | input | PC_W | Program counter of the observed load |
| obs_addr | input | ADDR_W | Data address of the observed load |
| pf_valid | output | 1 | Prefetch request valid (one-cycle pulse) |
| pf_addr | output | ADDR_W | Address to prefetch |

## Verification
The two functions that meet in one cycle are the emission of a prefetch for one observation and the update or eviction of a record by the very next observation, including an alias that lands on the same index. The bench provokes this with back-to-back observations drawn from a small set of program counters in which two share their index bits, interleaved with idle cycles, and with directed strides, repeated addresses and broken patterns. Each cycle it compares the prefetch pulse and address against a reference model of the table written from the requirements, so a stale read of a record just written, or a prefetch leaking through an eviction, shows up as a mismatch.

// File: rtl/stride_pf_pkg.sv
// Shared types for the stride prefetcher.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package stride_pf_pkg;
    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_TRANS  = 2'd1,
        ST_STEADY = 2'd2,
        ST_NOPRED = 2'd3
    } pf_state_e;
endpackage

// File: rtl/stride_table.sv
// Direct-mapped record store: combinational lookup by program counter,
// synchronous write of the looked-up record.
// Assumes: a write always targets the record selected by lk_pc in the same cycle.
module stride_table
    import stride_pf_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 4,
    parameter int IDX_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_prev,
    output logic [ADDR_W-1:0] lk_stride,
    output pf_state_e         lk_state,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_prev,
    input  logic [ADDR_W-1:0] wr_stride,
    input  pf_state_e         wr_state
);
    localparam int TAG_W = PC_W - IDX_W - IDX_LSB;
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;

    logic              vld_q    [DEPTH];
    logic [TAG_W-1:0]  tag_q    [DEPTH];
    logic [ADDR_W-1:0] prev_q   [DEPTH];
    logic [ADDR_W-1:0] stride_q [DEPTH];
    pf_state_e         state_q  [DEPTH];

    // Split the program counter into index and tag fields.
    always_comb begin
        idx = lk_pc[IDX_LSB +: IDX_W];
        tag = lk_pc[PC_W-1 -: TAG_W];
    end

    // Read the selected record and compare its tag.
    always_comb begin
        lk_hit    = vld_q[idx] && (tag_q[idx] == tag);
        lk_prev   = prev_q[idx];
        lk_stride = stride_q[idx];
        lk_state  = state_q[idx];
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_rec
        // Record i: cleared on reset, rewritten when selected by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i]    <= 1'b0;
                tag_q[i]    <= '0;
                prev_q[i]   <= '0;
                stride_q[i] <= '0;
                state_q[i]  <= ST_INIT;
            end else if (wr_en && (idx == IDX_W'(i))) begin
                vld_q[i]    <= 1'b1;
                tag_q[i]    <= tag;
                prev_q[i]   <= wr_prev;
                stride_q[i] <= wr_stride;
                state_q[i]  <= wr_state;
            end
        end
    end
endmodule

// File: rtl/stride_fsm.sv
// Confidence machine for one record: judges the new address and returns
// the record's next contents plus the prefetch decision.
// Assumes: purely combinational; inputs come from a lookup in the same cycle.
module stride_fsm
    import stride_pf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              hit,
    input  pf_state_e         cur_state,
    input  logic [ADDR_W-1:0] cur_prev,
    input  logic [ADDR_W-1:0] cur_stride,
    input  logic [ADDR_W-1:0] addr,
    output logic              correct,
    output pf_state_e         nxt_state,
    output logic [ADDR_W-1:0] nxt_stride,
    output logic              issue
);
    logic [ADDR_W-1:0] diff;

    // Compare the address with the prediction and form the new difference.
    always_comb begin
        diff    = addr - cur_prev;
        correct = hit && (addr == cur_prev + cur_stride);
    end

    // Next state and stride; allocation on a miss.
    always_comb begin
        nxt_state  = cur_state;
        nxt_stride = cur_stride;
        if (!hit) begin
            nxt_state  = ST_INIT;
            nxt_stride = '0;
        end else begin
            unique case (cur_state)
                ST_INIT: begin
                    if (correct) nxt_state = ST_STEADY;
                    else begin nxt_state = ST_TRANS;  nxt_stride = diff; end
                end
                ST_TRANS: begin
                    if (correct) nxt_state = ST_STEADY;
                    else begin nxt_state = ST_NOPRED; nxt_stride = diff; end
                end
                ST_STEADY: begin
                    if (!correct) nxt_state = ST_INIT;
                end
                ST_NOPRED: begin
                    if (correct) nxt_state = ST_TRANS;
                    else nxt_stride = diff;
                end
                default: nxt_state = ST_INIT;
            endcase
        end
    end

    // Issue only on a confirmed, non-zero stride.
    always_comb begin
        issue = correct && (nxt_state == ST_STEADY) && (cur_stride != '0);
    end
endmodule

// File: rtl/pf_issue.sv
// Output stage: registers the prefetch request one cycle after the observation.
// Assumes: fire is already qualified by the observation strobe.
module pf_issue #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] step,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    // Hold the pulse for one cycle and the target address until the next issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= fire;
            if (fire) pf_addr <= base + step;
        end
    end
endmodule

// File: rtl/stride_prefetcher.sv
// Top: per-load stride prefetcher. Looks up the record of each observed load,
// advances its confidence machine and issues a prefetch one stride ahead.
// Assumes: at most one observed load per cycle; synchronous active-low reset.
module stride_prefetcher
    import stride_pf_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 4,
    parameter int IDX_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obs_valid,
    input  logic [PC_W-1:0]   obs_pc,
    input  logic [ADDR_W-1:0] obs_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    logic              lk_hit;
    logic [ADDR_W-1:0] lk_prev;
    logic [ADDR_W-1:0] lk_stride;
    pf_state_e         lk_state;
    logic              lk_correct;
    pf_state_e         nx_state;
    logic [ADDR_W-1:0] nx_stride;
    logic              nx_issue;
    logic              fire;

    stride_table #(
        .PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .lk_pc(obs_pc),
        .lk_hit(lk_hit), .lk_prev(lk_prev), .lk_stride(lk_stride), .lk_state(lk_state),
        .wr_en(obs_valid), .wr_prev(obs_addr), .wr_stride(nx_stride), .wr_state(nx_state)
    );

    stride_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .hit(lk_hit), .cur_state(lk_state), .cur_prev(lk_prev), .cur_stride(lk_stride),
        .addr(obs_addr), .correct(lk_correct), .nxt_state(nx_state),
        .nxt_stride(nx_stride), .issue(nx_issue)
    );

    // Qualify the issue decision with the observation strobe.
    always_comb fire = obs_valid && nx_issue;

    pf_issue #(.ADDR_W(ADDR_W)) u_issue (
        .clk(clk), .rst_n(rst_n), .fire(fire), .base(obs_addr), .step(lk_stride),
        .pf_valid(pf_valid), .pf_addr(pf_addr)
    );
endmodule

// File: rtl/stride_prefetcher_chk.sv
// Checker for the stride prefetcher, bound to the top module.
// Assumes: attached through the bind statement below.
module stride_prefetcher_chk
    import stride_pf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              obs_valid,
    input logic [ADDR_W-1:0] obs_addr,
    input logic              lk_hit,
    input logic              lk_correct,
    input pf_state_e         lk_state,
    input logic [ADDR_W-1:0] lk_stride,
    input logic              pf_valid,
    input logic [ADDR_W-1:0] pf_addr
);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !obs_valid |=> !pf_valid);

    a_r2_alloc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_valid && !lk_hit) |=> !pf_valid);

    a_r8_from_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> ($past(obs_valid) && $past(lk_hit) && $past(lk_correct)));

    a_r9_nonzero_step: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr != $past(obs_addr)));

    a_r6_steady_keeps_issuing: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_valid && lk_hit && lk_correct && lk_state == ST_STEADY && lk_stride != '0)
        |=> (pf_valid && pf_addr == $past(obs_addr) + $past(lk_stride)));
endmodule

bind stride_prefetcher stride_prefetcher_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_addr(obs_addr),
    .lk_hit(lk_hit), .lk_correct(lk_correct), .lk_state(lk_state),
    .lk_stride(lk_stride), .pf_valid(pf_valid), .pf_addr(pf_addr)
);

// File: tb/tb_stride_prefetcher.sv
module tb_stride_prefetcher;
    localparam int PC_W = 32, ADDR_W = 32, IDX_W = 4, IDX_LSB = 2;
    localparam int DEPTH = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic obs_valid = 1'b0;
    logic [PC_W-1:0] obs_pc = '0;
    logic [ADDR_W-1:0] obs_addr = '0;
    logic pf_valid;
    logic [ADDR_W-1:0] pf_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stride_prefetcher #(.PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) dut (
        .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_pc(obs_pc),
        .obs_addr(obs_addr), .pf_valid(pf_valid), .pf_addr(pf_addr));

    // Reference model (0 init, 1 transient, 2 steady, 3 no-prediction)
    bit              m_vld [DEPTH];
    logic [31:0]     m_tag [DEPTH];
    logic [31:0]     m_prev[DEPTH];
    logic [31:0]     m_str [DEPTH];
    int              m_st  [DEPTH];
    bit              e_vld;
    logic [31:0]     e_addr;
    string           e_req;

    function automatic int idx_of(logic [31:0] pc);
        return int'(pc[IDX_LSB +: IDX_W]);
    endfunction

    function automatic logic [31:0] tag_of(logic [31:0] pc);
        return pc >> (IDX_LSB + IDX_W);
    endfunction

    // Applies one observation to the model and sets the expected output.
    function automatic void model_obs(logic [31:0] pc, logic [31:0] a);
        int i = idx_of(pc);
        bit ok;
        logic [31:0] d;
        e_vld = 0;
        if (!m_vld[i] || m_tag[i] != tag_of(pc)) begin
            m_vld[i] = 1; m_tag[i] = tag_of(pc); m_prev[i] = a; m_str[i] = 0; m_st[i] = 0;
            e_req = "R2/R11 allocate";
            return;
        end
        ok = (a == m_prev[i] + m_str[i]);
        d  = a - m_prev[i];
        case (m_st[i])
            0: begin e_req = "R4 init";
                     if (ok) m_st[i] = 2; else begin m_st[i] = 1; m_str[i] = d; end end
            1: begin e_req = "R5 transient";
                     if (ok) m_st[i] = 2; else begin m_st[i] = 3; m_str[i] = d; end end
            2: begin e_req = "R6 steady";
                     if (!ok) m_st[i] = 0; end
            default: begin e_req = "R7 no-prediction";
                     if (ok) m_st[i] = 1; else m_str[i] = d; end
        endcase
        if (ok && m_st[i] == 2) begin
            if (m_str[i] != 0) begin e_vld = 1; e_addr = a + m_str[i]; e_req = {e_req, " R8 issue"}; end
            else e_req = {e_req, " R9 zero stride"};
        end
        m_prev[i] = a; // R3
    endfunction

    task automatic check_out();
        n_chk++;
        if (pf_valid !== e_vld || (e_vld && pf_addr !== e_addr)) begin
            n_bad++;
            $display("FAIL %s: pf_valid=%0b pf_addr=%h expected pf_valid=%0b pf_addr=%h",
                     e_req, pf_valid, pf_addr, e_vld, e_addr);
        end
    endtask

    // Drive one cycle (observation or idle) at the falling edge and check the result.
    task automatic step(bit v, logic [31:0] pc, logic [31:0] a);
        obs_valid = v; obs_pc = pc; obs_addr = a;
        if (v) model_obs(pc, a);
        else begin e_vld = 0; e_req = "R10 idle"; end
        @(negedge clk);
        obs_valid = 0;
        check_out();
    endtask

    task automatic do_reset();
        rst_n = 0; obs_valid = 0;
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
        repeat (3) @(negedge clk);
        e_vld = 0; e_req = "R1 reset";
        check_out();
        rst_n = 1;
    endtask

    logic [31:0] pool_pc [5];
    logic [31:0] cur_a   [5];
    logic [31:0] cur_s   [5];

    initial begin
        @(negedge clk);
        do_reset();
        // R1/R2: first sighting allocates, no prefetch
        step(1, 32'h0000_1000, 32'h100);
        // R4 wrong -> transient with stride 0x10, R5 correct -> steady, R8 issue 0x130
        step(1, 32'h0000_1000, 32'h110);
        step(1, 32'h0000_1000, 32'h120);
        step(1, 32'h0000_1000, 32'h130);
        step(0, 0, 0);                        // R10
        // R6 wrong in steady -> init keeping stride; then correct again -> steady
        step(1, 32'h0000_1000, 32'h500);
        step(1, 32'h0000_1000, 32'h510);
        // R11 alias on same index evicts, then return reallocates
        step(1, 32'h0000_1040, 32'h900);
        step(1, 32'h0000_1000, 32'h520);
        // R9 repeated address reaches steady with zero stride: no prefetch
        step(1, 32'h0000_2004, 32'h40);
        step(1, 32'h0000_2004, 32'h40);
        step(1, 32'h0000_2004, 32'h40);
        // R7: force no-prediction, then stay, then go transient on a correct guess
        step(1, 32'h0000_3008, 32'h0);
        step(1, 32'h0000_3008, 32'h8);
        step(1, 32'h0000_3008, 32'h20);
        step(1, 32'h0000_3008, 32'h50);
        step(1, 32'h0000_3008, 32'h80);
        step(1, 32'h0000_3008, 32'hB0);
        // R3 wrap-around: negative stride
        step(1, 32'h0000_400C, 32'h20);
        step(1, 32'h0000_400C, 32'h18);
        step(1, 32'h0000_400C, 32'h10);
        step(1, 32'h0000_400C, 32'h8);

        // Random mix; 0x1000 and 0x1040 share an index (R11)
        pool_pc[0] = 32'h0000_1000; pool_pc[1] = 32'h0000_1040; pool_pc[2] = 32'h0000_2004;
        pool_pc[3] = 32'h0000_5010; pool_pc[4] = 32'h0000_603C;
        void'($urandom(32'd12345));
        for (int k = 0; k < 5; k++) begin
            cur_a[k] = $urandom; cur_s[k] = 32'(($urandom % 8) * 8);
        end
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom % 100);
            int k = int'($urandom % 5);
            if (r < 15) step(0, 0, 0);
            else begin
                if (r < 22) cur_a[k] = $urandom;
                else if (r < 27) cur_s[k] = 32'($urandom % 64) - 32;
                else cur_a[k] = cur_a[k] + cur_s[k];
                step(1, pool_pc[k], cur_a[k]);
            end
        end
        // R1 reset again mid-run clears the table
        do_reset();
        step(1, 32'h0000_1000, 32'h520);
        step(1, 32'h0000_1000, 32'h530);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule